// File: doc/BRIEF.md
# Burst Smoothing Word FIFO

This block is a small single-clock first-in-first-out buffer for 16-bit words. A producer that delivers data faster than its consumer can take it pushes words in. The consumer later pops them in the order they arrived, so no word is lost while the consumer is busy. The interface has a data input, separate push and pop request strobes, a data output, and `is_full` and `is_empty` status flags.

Storage is a bank of eight 16-bit registers. Two 3-bit pointers address it, one for writing and one for reading, and each wraps from 7 back to 0. The occupancy condition comes straight from a comparison of the two pointers. There is no wrap bit and no counter. That condition is held as one of three named conditions:

- `ST_EMPTY`: the pointers are equal.
- `ST_FULL`: the read pointer is one ahead of the write pointer.
- `ST_PARTIAL`: any other pointer pair.

Because of this encoding one slot always stays unused, so the buffer holds at most seven words.

The condition changes only through pointer movement:

- `ST_EMPTY -> ST_PARTIAL` on an accepted push.
- `ST_PARTIAL -> ST_FULL` on a push that brings the count to seven.
- `ST_FULL -> ST_PARTIAL` on an accepted pop.
- `ST_PARTIAL -> ST_EMPTY` on a pop of the last word.
- An accepted push and pop together stay in the same condition.

The read port is a combinational multiplexer that always shows the slot under the read pointer. Reset is synchronous and active-high.

Top module: `burst_fifo`

## Requirements
- R1: While `rst` is high at a clock edge, both pointers return to slot 0. From the next cycle `is_empty` is 1 and `is_full` is 0.
- R2: Words leave on `rd_data` in exactly the order in which they were accepted.
- R3: `is_empty` is 1 exactly when the read and write pointers are equal. A pop request while `is_empty` is 1 is ignored: the read pointer and `rd_data` contents are unaffected.
- R4: A push request while `is_full` is 1 is ignored. The write pointer does not move and no stored word is overwritten.
- R5: `is_full` is 1 exactly when the read pointer equals the write pointer plus one, modulo 8. This happens after seven unpopped pushes, so the usable capacity is seven words.
- R6: `rd_data` is a combinational read of the slot under the read pointer. After a push into an empty buffer, the pushed word is visible in the cycle right after that clock edge, and `is_empty` is 0 in that same cycle.
- R7: When push and pop are requested together and neither flag is set, both are accepted and the occupancy is unchanged.
- R8: Both requests are judged against the flags from before the edge. With both requested while empty, only the push is accepted. With both requested while full, only the pop is accepted.
- R9: The pointers wrap from 7 to 0, and order and flags stay correct across any number of wraps.
- R10: `is_full` and `is_empty` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset of both pointers |
| wr_data | input | 16 | Word to store on an accepted push |
| push_req | input | 1 | Push strobe, honoured only when not full |
| pop_req | input | 1 | Pop strobe, honoured only when not empty |
| rd_data | output | 16 | Oldest stored word; meaningful only when not empty |
| is_full | output | 1 | Seven words held, one slot left free |
| is_empty | output | 1 | No words held |

## Verification
The assertions assume that `push_req`, `pop_req` and `wr_data` are known (never X) at each rising edge after reset. They also assume that `rd_data` is judged only while `is_empty` is low, since the storage is never cleared. The stimulus changes every input only on the falling edge, from one task, and always drives defined values. The data checks are skipped whenever the reference queue is empty. The request patterns are built to push the buffer into both the full and the empty condition. They also drive requests against those flags there, as well as bursts long enough to wrap the pointers several times.

// File: rtl/burst_fifo_pkg.sv
package burst_fifo_pkg;

    localparam int WORD_W = 16;
    localparam int SLOTS  = 8;
    localparam int PTR_W  = $clog2(SLOTS);

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } occ_state_e;

endpackage

// File: rtl/fifo_ring_ptr.sv
module fifo_ring_ptr #(
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [PTR_W-1:0] ptr
);

    logic [PTR_W-1:0] ptr_q;

    // Power-of-two depth: the natural overflow of the adder is the wrap.
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (step) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/fifo_occ_decode.sv
module fifo_occ_decode
    import burst_fifo_pkg::*;
#(
    parameter int PTR_W = 3
) (
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [PTR_W-1:0] rd_ptr,
    output occ_state_e       state,
    output logic             full,
    output logic             empty
);

    logic [PTR_W-1:0] wr_next;

    assign wr_next = wr_ptr + 1'b1;

    // Condition decode from the registered pointers.
    always_comb begin
        if (rd_ptr == wr_ptr) begin
            state = ST_EMPTY;
        end else if (rd_ptr == wr_next) begin
            state = ST_FULL;
        end else begin
            state = ST_PARTIAL;
        end
    end

    // Flag outputs per condition.
    always_comb begin
        full  = 1'b0;
        empty = 1'b0;
        unique case (state)
            ST_EMPTY:   empty = 1'b1;
            ST_FULL:    full  = 1'b1;
            ST_PARTIAL: begin
                full  = 1'b0;
                empty = 1'b0;
            end
            default: begin
                full  = 1'b0;
                empty = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/fifo_reg_bank.sv
module fifo_reg_bank #(
    parameter int WORD_W = 16,
    parameter int SLOTS  = 8,
    parameter int PTR_W  = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word
);

    logic [WORD_W-1:0] slot_q [SLOTS];

    // One register per slot, loaded when the write index selects it.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == PTR_W'(s))) begin
                slot_q[s] <= wr_word;
            end
        end
    end

    assign rd_word = slot_q[rd_idx];

endmodule

// File: rtl/burst_fifo.sv
module burst_fifo
    import burst_fifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              push_req,
    input  logic              pop_req,
    output logic [WORD_W-1:0] rd_data,
    output logic              is_full,
    output logic              is_empty
);

    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             push_ok;
    logic             pop_ok;
    occ_state_e       occ;

    // Requests are gated by the flags from before the edge.
    assign push_ok = push_req && !is_full;
    assign pop_ok  = pop_req  && !is_empty;

    fifo_ring_ptr #(.PTR_W(PTR_W)) u_wr_ptr (
        .clk  (clk),
        .rst  (rst),
        .step (push_ok),
        .ptr  (wr_ptr)
    );

    fifo_ring_ptr #(.PTR_W(PTR_W)) u_rd_ptr (
        .clk  (clk),
        .rst  (rst),
        .step (pop_ok),
        .ptr  (rd_ptr)
    );

    fifo_occ_decode #(.PTR_W(PTR_W)) u_occ (
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .state  (occ),
        .full   (is_full),
        .empty  (is_empty)
    );

    fifo_reg_bank #(.WORD_W(WORD_W), .SLOTS(SLOTS), .PTR_W(PTR_W)) u_bank (
        .clk     (clk),
        .wr_en   (push_ok),
        .wr_idx  (wr_ptr),
        .wr_word (wr_data),
        .rd_idx  (rd_ptr),
        .rd_word (rd_data)
    );

endmodule

// File: rtl/burst_fifo_chk.sv
module burst_fifo_chk
    import burst_fifo_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] wr_data,
    input logic              push_req,
    input logic              pop_req,
    input logic [WORD_W-1:0] rd_data,
    input logic              is_full,
    input logic              is_empty,
    input logic [PTR_W-1:0]  wr_ptr,
    input logic [PTR_W-1:0]  rd_ptr
);

    // R1: the cycle after a reset edge shows an empty buffer.
    a_r1_reset_empty: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (is_empty && !is_full && wr_ptr == '0 && rd_ptr == '0));

    // R3: a pop alone against an empty buffer leaves it empty and still.
    a_r3_pop_empty_ignored: assert property (@(posedge clk) disable iff (rst)
        (is_empty && pop_req && !push_req) |=> (is_empty && $stable(rd_ptr)));

    // R4: a push alone against a full buffer changes neither pointer nor output.
    a_r4_push_full_ignored: assert property (@(posedge clk) disable iff (rst)
        (is_full && push_req && !pop_req)
            |=> (is_full && $stable(wr_ptr) && $stable(rd_data)));

    // R6: a push into an empty buffer is readable right after the edge.
    a_r6_first_word_visible: assert property (@(posedge clk) disable iff (rst)
        (is_empty && push_req) |=> (!is_empty && rd_data == $past(wr_data)));

    // R7: an accepted pair keeps both flags as they were.
    a_r7_pair_keeps_occ: assert property (@(posedge clk) disable iff (rst)
        (push_req && pop_req && !is_full && !is_empty)
            |=> ($stable(is_full) && $stable(is_empty)));

    // R8: both requests while full: only the pop moves a pointer.
    a_r8_pair_when_full: assert property (@(posedge clk) disable iff (rst)
        (is_full && push_req && pop_req)
            |=> (!is_full && $stable(wr_ptr) && rd_ptr == PTR_W'($past(rd_ptr) + 1'b1)));

    // R9: an accepted push advances the write pointer by one, wrapping.
    a_r9_wr_advance: assert property (@(posedge clk) disable iff (rst)
        (push_req && !is_full) |=> (wr_ptr == PTR_W'($past(wr_ptr) + 1'b1)));

    // R10: the flags exclude each other.
    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(is_full && is_empty));

endmodule

bind burst_fifo burst_fifo_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_data  (wr_data),
    .push_req (push_req),
    .pop_req  (pop_req),
    .rd_data  (rd_data),
    .is_full  (is_full),
    .is_empty (is_empty),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr)
);

// File: tb/sim_burst_fifo.sv
module sim_burst_fifo;

    localparam int CLK_PERIOD = 10;
    localparam int CAP        = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] wr_data = '0;
    logic        push_req = 1'b0;
    logic        pop_req = 1'b0;
    logic [15:0] rd_data;
    logic        is_full;
    logic        is_empty;

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] model_q[$];
    logic [15:0] lfsr = 16'hACE1;

    burst_fifo u0 (
        .clk      (clk),
        .rst      (rst),
        .wr_data  (wr_data),
        .push_req (push_req),
        .pop_req  (pop_req),
        .rd_data  (rd_data),
        .is_full  (is_full),
        .is_empty (is_empty)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Compare flags every cycle, and data whenever the model holds a word.
    task automatic compare(input string tag);
        check({tag, " empty"}, {15'd0, is_empty}, {15'd0, model_q.size() == 0});
        check({tag, " full"},  {15'd0, is_full},  {15'd0, model_q.size() == CAP});
        if (model_q.size() != 0) begin
            check({tag, " data"}, rd_data, model_q[0]);
        end
    endtask

    // Drive on the falling edge, update the model at the rising edge,
    // and compare on the following falling edge.
    task automatic step(input logic psh, input logic pp, input logic [15:0] d, input string tag);
        bit acc_push;
        bit acc_pop;
        push_req = psh;
        pop_req  = pp;
        wr_data  = d;
        @(posedge clk);
        acc_push = psh && (model_q.size() < CAP);
        acc_pop  = pp && (model_q.size() > 0);
        if (acc_pop)  void'(model_q.pop_front());
        if (acc_push) model_q.push_back(d);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        compare("R1 reset");

        // Fill to capacity (R5), then push against full (R4).
        for (int i = 0; i < CAP; i++) step(1'b1, 1'b0, 16'h1000 + 16'(i), "R5 fill");
        check("R5 full after seven", {15'd0, is_full}, 16'd1);
        step(1'b1, 1'b0, 16'hDEAD, "R4 push full");
        step(1'b1, 1'b0, 16'hBEEF, "R4 push full");

        // Both while full: only pop (R8).
        step(1'b1, 1'b1, 16'hCAFE, "R8 pair full");

        // Drain in order (R2), then pop against empty (R3).
        for (int i = 0; i < CAP - 1; i++) step(1'b0, 1'b1, 16'h0, "R2 drain");
        step(1'b0, 1'b1, 16'h0, "R3 pop empty");
        step(1'b0, 1'b1, 16'h0, "R3 pop empty");

        // Both while empty: only push (R8); word visible at once (R6).
        step(1'b1, 1'b1, 16'h5A5A, "R8 pair empty");
        check("R6 first word", rd_data, 16'h5A5A);

        // Sustained pairs at partial occupancy (R7).
        step(1'b1, 1'b0, 16'h0042, "R7 setup");
        for (int i = 0; i < 12; i++) step(1'b1, 1'b1, 16'h2000 + 16'(i), "R7 pair");

        // Pseudo-random traffic over many wraps (R9, R10).
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[5], lfsr[3] & ~(lfsr[7] & lfsr[9]), lfsr, "R9 traffic");
            check("R10 exclusive", {15'd0, is_full & is_empty}, 16'd0);
        end

        // Reset from a non-empty state (R1).
        step(1'b1, 1'b0, 16'h7777, "R1 pre");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_q.delete();
        compare("R1 mid reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule